// File: doc/BRIEF.md
# Accelerator control register block

This block is the control and status register file of a compute accelerator. It sits on a simple 32-bit register bus with separate write and read strobes. It tracks which units of four unit groups (shader, tiler, L2, L3) are powered. It decodes a command word, and it gathers completion events into a maskable interrupt.

Each unit group has a 64-bit presence mask, fixed by parameters. Each group also has a 64-bit ready mask, which software changes through power-on and power-off words. Each 64-bit quantity is split into a low and a high 32-bit word. A power-on write can only set ready bits for units that exist. A power-off write clears the named ready bits. Every power write posts two power-changed events.

Commands are selected by a small index. The block does no real sequencing work. A command only posts the matching completion event, and the two reset commands also return the register state to its reset values. Events collect in a raw status word, which is cleared by writing ones. Masked raw status drives a single interrupt line.

Top module: `accel_ctl_regs`

## Requirements
- R1: After reset:
  - raw status, mask and every ready word read 0, and irq is 0.
  - Present words read their parameter values. The defaults are shader low 0xF, tiler low 0x1, L2 low 0x1, and 0 for all other present words.
- R2: Reads are registered. rdata shows the addressed word in the cycle after the edge that samples rd_en, and holds it until the next read.
  - Control word addresses: 0x00 raw status, 0x01 clear, 0x02 mask, 0x03 status, 0x04 command.
  - Group g (shader 0, tiler 1, L2 2, L3 3) with half h (low 0, high 1) is at 2g+h plus a region base: present 0x10, ready 0x18, power-on 0x20, power-off 0x28.
  - Clear, command, power-on, power-off and unmapped addresses read 0.
- R3: Commands 0 (no-op), 3 (counter clear), 5 (cycle count start) and 6 (cycle count stop) change no readable state.
- R4: Commands 1 (soft reset) and 2 (hard reset) zero all ready words and the mask. They leave raw status holding only bit 18 (reset completed).
- R5: Command 4 sets raw bit 16 (sample completed). Commands 7 and 8 both set raw bit 17 (caches clean completed).
- R6: A write to a power-on word ORs the written value, ANDed with the present word of the same group and half, into the ready word of that group and half.
- R7: A write to a power-off word clears the bits of the matching ready word that are 1 in the written value.
- R8: Every power-on or power-off write sets raw bits 8 and 9 (power changed single, power changed all).
- R9: Writes to present words, ready words, raw status, status and unmapped addresses change no state.
- R10: A command value of 9 or more changes no state.
- R11: Writing ones to the clear word clears those raw bits. The mask keeps only bits 8, 9, 16, 17 and 18. Status reads raw AND mask, and irq is 1 exactly when status is nonzero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one word per cycle |
| rd_en | input | 1 | Read strobe |
| addr | input | ADDR_W | Word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| irq | output | 1 | Interrupt, OR of masked raw status |

## Verification
A write changes the state at the clock edge that samples it. The irq output follows that state with no extra register, so it is due one edge after the write. Read data passes through one more register, so it appears after the edge that samples rd_en. The bench drives inputs on falling edges and samples irq on the falling edge that ends the write. Its monitor compares rdata against the queued expected value on the falling edge after the edge where it recorded the read strobe. Each expected value is therefore checked exactly one register stage after its stimulus.

// File: rtl/accel_ctl_pkg.sv
package accel_ctl_pkg;
    localparam int DATA_W     = 32;
    localparam int NUM_GROUPS = 4;
    localparam int NUM_WORDS  = NUM_GROUPS * 2;
    localparam int CMD_COUNT  = 9;

    localparam int EV_PWR_ONE  = 8;
    localparam int EV_PWR_ALL  = 9;
    localparam int EV_SAMPLE   = 16;
    localparam int EV_CLEAN    = 17;
    localparam int EV_RESET    = 18;

    localparam logic [DATA_W-1:0] EV_IMPL =
        (DATA_W'(1) << EV_PWR_ONE) | (DATA_W'(1) << EV_PWR_ALL) |
        (DATA_W'(1) << EV_SAMPLE)  | (DATA_W'(1) << EV_CLEAN)   |
        (DATA_W'(1) << EV_RESET);

    typedef enum logic [3:0] {
        CMD_NOP      = 4'd0,
        CMD_SRST     = 4'd1,
        CMD_HRST     = 4'd2,
        CMD_CNT_CLR  = 4'd3,
        CMD_CNT_SMP  = 4'd4,
        CMD_CYC_GO   = 4'd5,
        CMD_CYC_HALT = 4'd6,
        CMD_CLEAN    = 4'd7,
        CMD_CLEAN_IV = 4'd8
    } cmd_e;

    typedef struct packed {
        logic [NUM_WORDS-1:0][DATA_W-1:0] ready;
        logic [DATA_W-1:0]                raw;
        logic [DATA_W-1:0]                mask;
        logic [DATA_W-1:0]                rdata;
    } ctl_state_t;
endpackage

// File: rtl/accel_cmd_decode.sv
module accel_cmd_decode
    import accel_ctl_pkg::*;
(
    input  logic              valid,
    input  logic [DATA_W-1:0] code,
    output logic              do_reset,
    output logic [DATA_W-1:0] events
);
    always_comb begin
        do_reset = 1'b0;
        events   = '0;
        if (valid && (code < DATA_W'(CMD_COUNT))) begin
            case (cmd_e'(code[3:0]))
                CMD_SRST, CMD_HRST: begin
                    do_reset = 1'b1;
                    events[EV_RESET] = 1'b1;
                end
                CMD_CNT_SMP:            events[EV_SAMPLE] = 1'b1;
                CMD_CLEAN, CMD_CLEAN_IV: events[EV_CLEAN] = 1'b1;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/accel_pwr_word.sv
module accel_pwr_word
    import accel_ctl_pkg::*;
(
    input  logic [DATA_W-1:0] cur,
    input  logic [DATA_W-1:0] present,
    input  logic [DATA_W-1:0] wdata,
    input  logic              on_hit,
    input  logic              off_hit,
    output logic [DATA_W-1:0] nxt
);
    always_comb begin
        nxt = cur;
        if (on_hit)  nxt = cur | (wdata & present);
        if (off_hit) nxt = cur & ~wdata;
    end
endmodule

// File: rtl/accel_ctl_regs.sv
module accel_ctl_regs
    import accel_ctl_pkg::*;
#(
    parameter int          ADDR_W         = 6,
    parameter logic [63:0] SHADER_PRESENT = 64'hF,
    parameter logic [63:0] TILER_PRESENT  = 64'h1,
    parameter logic [63:0] L2_PRESENT     = 64'h1,
    parameter logic [63:0] L3_PRESENT     = 64'h0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              irq
);
    localparam int REGION_W = ADDR_W - 3;
    localparam logic [REGION_W-1:0] RG_CTRL = REGION_W'(0);
    localparam logic [REGION_W-1:0] RG_PRES = REGION_W'(2);
    localparam logic [REGION_W-1:0] RG_RDY  = REGION_W'(3);
    localparam logic [REGION_W-1:0] RG_ON   = REGION_W'(4);
    localparam logic [REGION_W-1:0] RG_OFF  = REGION_W'(5);
    localparam logic [2:0] CW_RAW  = 3'd0;
    localparam logic [2:0] CW_CLR  = 3'd1;
    localparam logic [2:0] CW_MASK = 3'd2;
    localparam logic [2:0] CW_STAT = 3'd3;
    localparam logic [2:0] CW_CMD  = 3'd4;
    localparam logic [NUM_WORDS-1:0][DATA_W-1:0] PRES =
        {L3_PRESENT, L2_PRESENT, TILER_PRESENT, SHADER_PRESENT};

    ctl_state_t st_d, st_q;

    logic [REGION_W-1:0] region;
    logic [2:0]          idx;
    logic                ctrl_wr, cmd_do_reset;
    logic [DATA_W-1:0]   cmd_events;
    logic [NUM_WORDS-1:0] on_hit, off_hit;
    logic [NUM_WORDS-1:0][DATA_W-1:0] ready_nxt;

    assign region  = addr[ADDR_W-1:3];
    assign idx     = addr[2:0];
    assign ctrl_wr = wr_en && (region == RG_CTRL);

    accel_cmd_decode u_cmd (
        .valid    (ctrl_wr && (idx == CW_CMD)),
        .code     (wdata),
        .do_reset (cmd_do_reset),
        .events   (cmd_events)
    );

    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
        assign on_hit[w]  = wr_en && (region == RG_ON)  && (idx == 3'(w));
        assign off_hit[w] = wr_en && (region == RG_OFF) && (idx == 3'(w));
        accel_pwr_word u_pwr (
            .cur     (st_q.ready[w]),
            .present (PRES[w]),
            .wdata   (wdata),
            .on_hit  (on_hit[w]),
            .off_hit (off_hit[w]),
            .nxt     (ready_nxt[w])
        );
    end

    always_comb begin
        logic [DATA_W-1:0] rd_mux;
        logic [DATA_W-1:0] pwr_ev;
        st_d  = st_q;
        st_d.ready = ready_nxt;
        pwr_ev = '0;
        if ((on_hit | off_hit) != '0) begin
            pwr_ev[EV_PWR_ONE] = 1'b1;
            pwr_ev[EV_PWR_ALL] = 1'b1;
        end
        if (ctrl_wr && (idx == CW_CLR))  st_d.raw  = st_q.raw & ~wdata;
        if (ctrl_wr && (idx == CW_MASK)) st_d.mask = wdata & EV_IMPL;
        st_d.raw = st_d.raw | pwr_ev | cmd_events;
        if (cmd_do_reset) begin
            st_d.ready = '0;
            st_d.mask  = '0;
            st_d.raw   = cmd_events;
        end

        rd_mux = '0;
        case (region)
            RG_CTRL: begin
                case (idx)
                    CW_RAW:  rd_mux = st_q.raw;
                    CW_MASK: rd_mux = st_q.mask;
                    CW_STAT: rd_mux = st_q.raw & st_q.mask;
                    default: rd_mux = '0;
                endcase
            end
            RG_PRES: rd_mux = PRES[idx];
            RG_RDY:  rd_mux = st_q.ready[idx];
            default: rd_mux = '0;
        endcase
        if (rd_en) st_d.rdata = rd_mux;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rdata = st_q.rdata;
    assign irq   = |(st_q.raw & st_q.mask);
endmodule

// File: rtl/accel_ctl_checker.sv
module accel_ctl_checker
    import accel_ctl_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter logic [NUM_WORDS*DATA_W-1:0] PRES = '0
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        wr_en,
    input logic [ADDR_W-1:0]           addr,
    input logic [DATA_W-1:0]           wdata,
    input logic                        irq,
    input logic [NUM_WORDS*DATA_W-1:0] ready_i,
    input logic [DATA_W-1:0]           raw_i,
    input logic [DATA_W-1:0]           mask_i
);
    localparam int REGION_W = ADDR_W - 3;
    logic [REGION_W-1:0] region;
    logic [2:0]          idx;
    logic is_cmd, is_pwr, is_dropped;

    assign region = addr[ADDR_W-1:3];
    assign idx    = addr[2:0];
    assign is_cmd = wr_en && (region == REGION_W'(0)) && (idx == 3'd4);
    assign is_pwr = wr_en && ((region == REGION_W'(4)) || (region == REGION_W'(5)));
    assign is_dropped = wr_en && (
        (region == REGION_W'(2)) || (region == REGION_W'(3)) ||
        (region >= REGION_W'(6)) || (region == REGION_W'(1)) ||
        ((region == REGION_W'(0)) && ((idx == 3'd0) || (idx == 3'd3) || (idx >= 3'd5))));

    assert_ready_within_present_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_i & ~PRES) == '0);

    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_off
        assert_off_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && (region == REGION_W'(5)) && (idx == 3'(w)))
            |=> ((ready_i[w*DATA_W +: DATA_W] & $past(wdata)) == '0));
    end

    assert_pwr_events_R8: assert property (@(posedge clk) disable iff (!rst_n)
        is_pwr |=> (raw_i[EV_PWR_ONE] && raw_i[EV_PWR_ALL]));

    assert_reset_cmd_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (is_cmd && ((wdata == 32'd1) || (wdata == 32'd2)))
        |=> ((raw_i == (32'd1 << EV_RESET)) && (ready_i == '0) && (mask_i == '0)));

    assert_big_cmd_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (is_cmd && (wdata >= 32'd9))
        |=> ($stable(ready_i) && $stable(raw_i) && $stable(mask_i)));

    assert_dropped_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        is_dropped |=> ($stable(ready_i) && $stable(raw_i) && $stable(mask_i)));

    assert_irq_fall_needs_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq) |-> $past(wr_en));
endmodule

bind accel_ctl_regs accel_ctl_checker #(.ADDR_W(ADDR_W), .PRES(PRES)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .addr    (addr),
    .wdata   (wdata),
    .irq     (irq),
    .ready_i (st_q.ready),
    .raw_i   (st_q.raw),
    .mask_i  (st_q.mask)
);

// File: tb/test_accel_ctl_regs.sv
`timescale 1ns/1ps
module test_accel_ctl_regs;
    localparam int AW = 6;
    localparam logic [AW-1:0] A_RAW = 6'h00, A_CLR = 6'h01, A_MASK = 6'h02,
        A_STAT = 6'h03, A_CMD = 6'h04, A_PRES = 6'h10, A_RDY = 6'h18,
        A_ON = 6'h20, A_OFF = 6'h28, A_HOLE = 6'h30;

    logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [31:0] wdata = '0, rdata;
    logic irq;
    int n_run = 0, n_fail = 0;
    logic rd_seen = 1'b0;
    logic [31:0] exp_q[$];
    string tag_q[$];
    bit done = 1'b0;

    always #10 clk = ~clk;

    accel_ctl_regs i_accel_ctl_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
    );

    always @(posedge clk) rd_seen <= rd_en;

    always @(negedge clk) begin
        if (rd_seen && exp_q.size() > 0) begin
            logic [31:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            n_run++;
            if (rdata !== e) begin
                n_fail++;
                $display("FAIL %s: rdata=%08h expected=%08h", t, rdata, e);
            end
        end
    end

    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, input logic [31:0] e, input string t);
        @(negedge clk);
        exp_q.push_back(e); tag_q.push_back(t);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic chk_irq(input logic e, input string t);
        n_run++;
        if (irq !== e) begin
            n_fail++;
            $display("FAIL %s: irq=%0b expected=%0b", t, irq, e);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk_irq(1'b0, "R1 irq after reset");
        rd(A_RAW, 32'h0, "R1 raw after reset");
        rd(A_MASK, 32'h0, "R1 mask after reset");
        rd(A_RDY, 32'h0, "R1 shader ready lo");
        rd(A_PRES, 32'hF, "R1 shader present lo");
        rd(A_PRES + 6'd2, 32'h1, "R1 tiler present lo");
        rd(A_PRES + 6'd6, 32'h0, "R1 L3 present lo");
        rd(A_CMD, 32'h0, "R2 command reads zero");

        wr(A_ON, 32'hFF);
        rd(A_RDY, 32'hF, "R6 shader lo masked by present");
        rd(A_RAW, 32'h300, "R8 power events after power-on");
        wr(A_CLR, 32'h300);
        wr(A_ON + 6'd1, 32'hFFFF_FFFF);
        rd(A_RDY + 6'd1, 32'h0, "R6 shader hi no units");
        wr(A_ON + 6'd2, 32'h3);
        rd(A_RDY + 6'd2, 32'h1, "R6 tiler lo");
        rd(A_RDY, 32'hF, "R6 shader lo untouched by tiler");
        wr(A_ON + 6'd6, 32'h1);
        rd(A_RDY + 6'd6, 32'h0, "R6 L3 lo no units");

        wr(A_CLR, 32'h300);
        wr(A_OFF, 32'h5);
        rd(A_RDY, 32'hA, "R7 shader lo after power-off");
        rd(A_RAW, 32'h300, "R8 power events after power-off");

        wr(A_RDY, 32'hFFFF);
        wr(A_PRES, 32'h0);
        wr(A_HOLE, 32'hFFFF_FFFF);
        wr(A_RAW, 32'h0);
        wr(A_STAT, 32'h0);
        rd(A_RDY, 32'hA, "R9 ready write dropped");
        rd(A_PRES, 32'hF, "R9 present write dropped");
        rd(A_RAW, 32'h300, "R9 raw write dropped");
        rd(A_HOLE, 32'h0, "R2 unmapped reads zero");

        wr(A_MASK, 32'hFFFF_FFFF);
        chk_irq(1'b1, "R11 irq with mask set");
        rd(A_MASK, 32'h0007_0300, "R11 mask implemented bits");
        wr(A_MASK, 32'h200);
        rd(A_STAT, 32'h200, "R11 status is raw and mask");
        wr(A_CLR, 32'h200);
        chk_irq(1'b0, "R11 irq after clearing masked bit");
        rd(A_RAW, 32'h100, "R11 clear is write one");
        wr(A_CLR, 32'h100);
        wr(A_MASK, 32'hFFFF_FFFF);
        chk_irq(1'b0, "R11 irq with nothing raw");

        wr(A_CMD, 32'd0); wr(A_CMD, 32'd3); wr(A_CMD, 32'd5); wr(A_CMD, 32'd6);
        rd(A_RAW, 32'h0, "R3 quiet commands raw");
        rd(A_RDY, 32'hA, "R3 quiet commands ready");
        chk_irq(1'b0, "R3 quiet commands irq");

        wr(A_CMD, 32'd4);
        chk_irq(1'b1, "R5 sample raises irq");
        rd(A_RAW, 32'h1_0000, "R5 sample completed");
        wr(A_CLR, 32'hFFFF_FFFF);
        wr(A_CMD, 32'd7);
        rd(A_RAW, 32'h2_0000, "R5 clean completed");
        wr(A_CLR, 32'hFFFF_FFFF);
        wr(A_CMD, 32'd8);
        rd(A_RAW, 32'h2_0000, "R5 clean invalidate completed");

        wr(A_CMD, 32'd9);
        wr(A_CMD, 32'hFFFF_FFFF);
        rd(A_RAW, 32'h2_0000, "R10 big command raw");
        rd(A_RDY, 32'hA, "R10 big command ready");
        rd(A_MASK, 32'h0007_0300, "R10 big command mask");

        wr(A_CMD, 32'd2);
        chk_irq(1'b0, "R4 hard reset clears mask");
        rd(A_RAW, 32'h4_0000, "R4 hard reset raw");
        rd(A_RDY, 32'h0, "R4 hard reset shader ready");
        rd(A_RDY + 6'd2, 32'h0, "R4 hard reset tiler ready");
        rd(A_MASK, 32'h0, "R4 hard reset mask");
        wr(A_ON, 32'h3);
        wr(A_MASK, 32'h300);
        wr(A_CMD, 32'd1);
        rd(A_RAW, 32'h4_0000, "R4 soft reset raw");
        rd(A_RDY, 32'h0, "R4 soft reset ready");
        wr(A_MASK, 32'h4_0000);
        chk_irq(1'b1, "R4 reset completed survives");

        repeat (3) @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        #200000;
        if (!done) begin
            done = 1'b1;
            n_run++; n_fail++;
            $display("FAIL watchdog: run=1 expected=0");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule